// File: doc/BRIEF.md
# Power-Up Serial EEPROM Boot Selector

After reset, this sequencer reads an optional serial EEPROM one byte at a time. It uses a simple request/response port in front of an I2C master, which runs as master only at 100 kHz or 400 kHz. The first byte is a signature, and it selects one of three outcomes:

- **`0xC0`**: the next six bytes replace the built-in vendor, product and release identifiers.
- **`0xC2`**: a chain of records is copied into internal RAM through a byte write port.
- **Anything else, or no acknowledge**: the built-in identifiers stay in force. These are vendor `0x04B4`, product `0x8613` and release `0xA` followed by the 12-bit revision.

The CPU is held in reset until the sequence ends. After that the block is idle until the next reset.

Each bootload record has four header bytes, high byte first: a length word and a target address word. The data bytes follow the header. A length word with bit 15 set closes the chain.

Top module: `boot_select`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `cpu_hold`=1, `boot_done`=0, `vid`=0x04B4, `pid`=0x8613, `did`={4'hA, REV}. On release, a request for EEPROM address 0 is raised.
- R2: Each accepted byte (`rd_done`=1 with `rd_nak`=0 while `rd_req`=1) advances `rd_addr` by exactly one on the next cycle.
- R3: A `rd_nak` on the signature read ends the sequence. The default identifiers are kept and no RAM write occurs.
- R4: A signature other than 0xC0 or 0xC2 ends the sequence after that one byte. The defaults are kept and there are no RAM writes.
- R5: Signature 0xC0 loads six following bytes in this order: vendor low, vendor high, product low, product high, release low, release high. The identifiers then stay frozen.
- R6: A `rd_nak` part-way through the six identifier bytes leaves all three identifiers at their defaults.
- R7: Signature 0xC2 writes each data byte to the record's target address, which is truncated to AW bits. The address increments per byte and wraps from 0x3FFF to 0x0000 when AW=14. A write only happens on an accepted byte.
- R8: A record length of zero writes nothing, and the header of the next record follows. A length word with bit 15 set ends the chain. `cpu_hold` stays at 1 during every RAM write.
- R9: Once `boot_done` rises, it stays high and `cpu_hold` is 0. Neither `rd_req` nor `ram_we` is raised again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | output | 1 | Byte read requested at `rd_addr` |
| rd_addr | output | EW | EEPROM byte address |
| rd_done | input | 1 | One-cycle response strobe |
| rd_nak | input | 1 | With `rd_done`: no acknowledge from the EEPROM |
| rd_data | input | 8 | Byte read, valid with `rd_done` |
| ram_we | output | 1 | Internal RAM byte write strobe |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| vid | output | 16 | Vendor identifier in force |
| pid | output | 16 | Product identifier in force |
| did | output | 16 | Release identifier in force |
| boot_done | output | 1 | Sequence finished |
| cpu_hold | output | 1 | CPU held in reset |

## Verification
The signatures tried are 0xC0, 0xC2, 0xFF and 0xC1, plus an EEPROM that never acknowledges. These separate the override path, the copy path and the two ways of falling back to defaults.

The bootload image has three records after the signature:
- a normal record;
- a zero-length record, which shows that an empty record writes nothing;
- a record that starts at the top RAM address, which shows the address wraps.

A no-acknowledge injected at the fourth identifier byte shows that a partial override is never applied. The bench also checks the exact list of RAM writes. It checks that the CPU stays held during every write, and that requests stop once the sequence ends.

// File: rtl/boot_select.sv
module boot_select #(
  parameter int          AW  = 14,
  parameter int          EW  = 16,
  parameter logic [11:0] REV = 12'h001
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rd_req,
  output logic [EW-1:0] rd_addr,
  input  logic          rd_done,
  input  logic          rd_nak,
  input  logic [7:0]    rd_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic [15:0]   vid,
  output logic [15:0]   pid,
  output logic [15:0]   did,
  output logic          boot_done,
  output logic          cpu_hold
);
  typedef enum logic [2:0] {SIG, IDS, LEN, ADR, DAT, FIN} st_t;

  st_t          st;
  logic         ph;
  logic [2:0]   n;
  logic [7:0]   hi;
  logic [14:0]  len;
  logic [39:0]  sh;
  logic [AW-1:0] tgt;

  wire        live = (st != FIN);
  wire        take = rd_done & ~rd_nak & live;
  wire [15:0] pair = {hi, rd_data};

  assign rd_req    = live;
  assign boot_done = ~live;
  assign cpu_hold  = live;
  assign ram_we    = take & (st == DAT);
  assign ram_addr  = tgt;
  assign ram_wdata = rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SIG;
      ph      <= 1'b0;
      n       <= '0;
      hi      <= '0;
      len     <= '0;
      sh      <= '0;
      tgt     <= '0;
      rd_addr <= '0;
      vid     <= 16'h04B4;
      pid     <= 16'h8613;
      did     <= {4'hA, REV};
    end else if (rd_done && rd_nak && live) begin
      st <= FIN;
    end else if (take) begin
      rd_addr <= rd_addr + 1'b1;
      case (st)
        SIG: begin
          ph <= 1'b0;
          n  <= '0;
          if (rd_data == 8'hC0)      st <= IDS;
          else if (rd_data == 8'hC2) st <= LEN;
          else                       st <= FIN;
        end
        IDS: begin
          sh <= {rd_data, sh[39:8]};
          n  <= n + 1'b1;
          if (n == 3'd5) begin
            vid <= sh[15:0];
            pid <= sh[31:16];
            did <= {rd_data, sh[39:32]};
            st  <= FIN;
          end
        end
        LEN: begin
          ph <= ~ph;
          if (!ph) hi <= rd_data;
          else begin
            len <= pair[14:0];
            st  <= hi[7] ? FIN : ADR;
          end
        end
        ADR: begin
          ph <= ~ph;
          if (!ph) hi <= rd_data;
          else begin
            tgt <= pair[AW-1:0];
            st  <= (len == '0) ? LEN : DAT;
          end
        end
        DAT: begin
          tgt <= tgt + 1'b1;
          len <= len - 1'b1;
          if (len == 15'd1) st <= LEN;
        end
        default: st <= FIN;
      endcase
    end
  end
endmodule

// File: rtl/boot_select_chk.sv
module boot_select_chk #(
  parameter int AW = 14,
  parameter int EW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [EW-1:0] rd_addr,
  input logic          rd_done,
  input logic          rd_nak,
  input logic          ram_we,
  input logic [15:0]   vid,
  input logic [15:0]   pid,
  input logic [15:0]   did,
  input logic          boot_done,
  input logic          cpu_hold
);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_done && !rd_nak |=> rd_addr == EW'($past(rd_addr) + 1'b1));

  p_nak_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_done && rd_nak |=> boot_done);

  p_ids_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> $stable(vid) && $stable(pid) && $stable(did));

  p_write_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> rd_done && !rd_nak);

  p_held_in_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> cpu_hold);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done && !cpu_hold);

  p_quiet_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !rd_req && !ram_we);
endmodule

bind boot_select boot_select_chk #(.AW(AW), .EW(EW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_done(rd_done), .rd_nak(rd_nak), .ram_we(ram_we),
  .vid(vid), .pid(pid), .did(did), .boot_done(boot_done), .cpu_hold(cpu_hold));

// File: tb/test_boot_select.sv
module test_boot_select;
  logic        clk = 0, rst_n = 0;
  logic        rd_req, rd_done, rd_nak, ram_we, boot_done, cpu_hold;
  logic [15:0] rd_addr, vid, pid, did;
  logic [7:0]  rd_data, ram_wdata;
  logic [13:0] ram_addr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  boot_select i_boot_select (.*);

  logic [7:0] mem [0:63];
  int nak_at = -1;
  int lat;
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_done <= 0; rd_nak <= 0; rd_data <= 0; lat <= 0;
    end else begin
      rd_done <= 0; rd_nak <= 0;
      if (rd_done) lat <= 0;
      else if (rd_req) begin
        if (lat == 2) begin
          rd_done <= 1;
          rd_nak  <= (int'(rd_addr) == nak_at);
          rd_data <= mem[rd_addr[5:0]];
          lat     <= 0;
        end else lat <= lat + 1;
      end
    end
  end

  logic [13:0] wa [0:15];
  logic [7:0]  wd [0:15];
  int nw;
  logic hold_bad;
  always @(posedge clk) begin
    if (!rst_n) begin nw <= 0; hold_bad <= 0; end
    else if (ram_we) begin
      if (nw < 16) begin wa[nw] <= ram_addr; wd[nw] <= ram_wdata; end
      nw <= nw + 1;
      if (!cpu_hold) hold_bad <= 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input logic [7:0] sig);
    for (int k = 0; k < 64; k++) mem[k] = 8'h00;
    mem[0] = sig;
    if (sig == 8'hC2) begin
      mem[1]=8'h00; mem[2]=8'h03; mem[3]=8'h00; mem[4]=8'h10;
      mem[5]=8'hA1; mem[6]=8'hA2; mem[7]=8'hA3;
      mem[8]=8'h00; mem[9]=8'h00; mem[10]=8'h00; mem[11]=8'h20;
      mem[12]=8'h00; mem[13]=8'h02; mem[14]=8'h3F; mem[15]=8'hFF;
      mem[16]=8'hB1; mem[17]=8'hB2;
      mem[18]=8'h80; mem[19]=8'h00;
    end else begin
      for (int k = 1; k <= 6; k++) mem[k] = 8'(k * 8'h11);
    end
  endtask

  task automatic run(input bit first);
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (first) begin
      chk(cpu_hold === 1 && boot_done === 0, "R1 hold/done in reset", {cpu_hold, boot_done}, 2'b10);
      chk(vid === 16'h04B4 && pid === 16'h8613, "R1 default vid/pid", {vid, pid}, 32'h04B48613);
      chk(did === 16'hA001, "R1 default did", did, 16'hA001);
    end
    rst_n = 1;
    @(negedge clk);
    if (first) chk(rd_req === 1 && rd_addr === 16'h0000, "R1 first request at 0", {rd_req, rd_addr}, 17'h10000);
    for (int t = 0; t < 500 && boot_done !== 1; t++) @(negedge clk);
    chk(boot_done === 1, "R9 sequence finished (watchdog)", boot_done, 1);
    repeat (3) @(negedge clk);
    chk(boot_done === 1 && cpu_hold === 0 && rd_req === 0 && ram_we === 0,
        "R9 idle and released after done", {boot_done, cpu_hold, rd_req, ram_we}, 4'b1000);
  endtask

  // sig, nak-on-first, vid, pid, did, expected RAM writes
  localparam logic [64:0] VEC [5] = '{
    {8'hC0, 1'b0, 16'h2211, 16'h4433, 16'h6655, 8'd0},
    {8'hC2, 1'b0, 16'h04B4, 16'h8613, 16'hA001, 8'd5},
    {8'hFF, 1'b0, 16'h04B4, 16'h8613, 16'hA001, 8'd0},
    {8'hC1, 1'b0, 16'h04B4, 16'h8613, 16'hA001, 8'd0},
    {8'hC0, 1'b1, 16'h04B4, 16'h8613, 16'hA001, 8'd0}
  };

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R9 global watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      logic [64:0] v;
      v = VEC[i];
      build(v[64:57]);
      nak_at = v[56] ? 0 : -1;
      run(i == 0);
      chk(vid === v[55:40], "R5/R3/R4 vid", vid, v[55:40]);
      chk(pid === v[39:24], "R5/R3/R4 pid", pid, v[39:24]);
      chk(did === v[23:8],  "R5/R3/R4 did", did, v[23:8]);
      chk(nw == int'(v[7:0]), "R7/R3/R4 ram write count", nw, v[7:0]);
    end

    // R7 R8: content and order of bootload writes, zero-length record, wrap
    build(8'hC2); nak_at = -1;
    run(0);
    chk(nw == 5, "R8 zero-length record adds no write", nw, 5);
    chk(wa[0] == 14'h0010 && wd[0] == 8'hA1, "R7 write 0", {wa[0], wd[0]}, {14'h0010, 8'hA1});
    chk(wa[1] == 14'h0011 && wd[1] == 8'hA2, "R7 write 1", {wa[1], wd[1]}, {14'h0011, 8'hA2});
    chk(wa[2] == 14'h0012 && wd[2] == 8'hA3, "R7 write 2", {wa[2], wd[2]}, {14'h0012, 8'hA3});
    chk(wa[3] == 14'h3FFF && wd[3] == 8'hB1, "R7 write 3 top", {wa[3], wd[3]}, {14'h3FFF, 8'hB1});
    chk(wa[4] == 14'h0000 && wd[4] == 8'hB2, "R7 write 4 wrap", {wa[4], wd[4]}, {14'h0000, 8'hB2});
    chk(hold_bad == 0, "R8 cpu held during every write", hold_bad, 0);
    chk(rd_addr == 16'd20, "R2 one address step per byte", rd_addr, 20);

    // R6: no acknowledge at the fourth identifier byte
    build(8'hC0); nak_at = 4;
    run(0);
    chk(vid === 16'h04B4 && pid === 16'h8613 && did === 16'hA001, "R6 partial override discarded",
        {vid, pid}, 32'h04B48613);
    chk(rd_addr == 16'd4, "R2 address stops at failed byte", rd_addr, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule